// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block controls a port of up to 32 pins. Each pin has a two-bit function selector, a direction bit, a pull-up disable bit and one bit of output latch. The selector hands the pin either to the general-purpose logic or to one of three peripheral signal sets. Each peripheral set supplies its own output value and output enable for every pin. Software changes the output latch through a plain data register, or one bit at a time through set, clear and toggle registers. The pad levels pass through a two-stage synchronizer. They can then be read back and are also passed on to the peripherals.

Writes to a function selector show up in the register readback at once. The pad multiplexer uses the new setting exactly two clock edges after the write. Three external interrupt lines each watch one port pin, picked by a five-bit field. Each line gives a one-cycle pulse on the falling edge or the rising edge of that pin, as its polarity bit selects. A wake mask raises the wake output while any masked pin is low. Out of reset, every pin is a general-purpose input with its latch at zero. The pull-up disable bits take a per-pin reset pattern given as a parameter, so that pins able to carry PWM outputs come up with the pull-up off.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every function code is 0 (general purpose), every direction bit is 0 and the output latch is 0, so pad_oe and pad_out are all zero whatever the peripherals drive.
- R2: The pull-up disable register resets to the parameter PUD_RESET and is rewritable at address 5, and pad_pu_en is always its bitwise inverse.
- R3: Address 0 loads the latch with the written word. A 1 written at address 1 sets, at address 2 clears, and at address 3 inverts that pin's latch bit. A 0 in any of these three leaves the bit unchanged.
- R4: A pin in general-purpose mode drives pad_out from its latch and pad_oe from its direction bit (address 4, 1 = output). A latch value loaded before the direction is switched is the first value driven.
- R5: Function code 1, 2 or 3 routes the pin's output and enable from peripheral set A, B or C. Pin i's code sits in bits 2i+1:2i of address 6 for pins 0 to 15, and in bits 2(i-16)+1:2(i-16) of address 7 for pins 16 to 31.
- R6: A function-select write reads back at once, but the pad multiplexer uses it exactly two clock edges after the edge that captured the write.
- R7: Each pad input passes through two flip-flops. Address 0 reads the synchronized level whatever the direction. A pad change shows up after the second rising edge and not after the first.
- R8: Addresses 9, 10 and 11 configure interrupt lines 0, 1 and 2. Bits 4:0 pick the pin and bit 8 picks the edge (1 = rising, 0 = falling). On that edge of the synchronized pin, xint_pulse for the line is high for exactly one cycle.
- R9: wake_o is high while any pin whose bit is set in the wake mask (address 8) has a synchronized level of 0. It stays low while the mask is zero.
- R10: Addresses 1, 2 and 3 read back as zero. Every other register address reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| pad_in | input | NPINS | Raw pad input levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| pad_pu_en | output | NPINS | Pull-up enables |
| per_a_out | input | NPINS | Peripheral set A output values |
| per_a_oe | input | NPINS | Peripheral set A output enables |
| per_b_out | input | NPINS | Peripheral set B output values |
| per_b_oe | input | NPINS | Peripheral set B output enables |
| per_c_out | input | NPINS | Peripheral set C output values |
| per_c_oe | input | NPINS | Peripheral set C output enables |
| pin_level | output | NPINS | Synchronized pad levels for the peripherals |
| xint_pulse | output | NXINT | Interrupt edge pulses, one per line |
| wake_o | output | 1 | Wake request |

## Verification
The hardest case to reach is the window between a function-select write and the moment it takes effect. The register already reads the new code, yet the pads still follow the old owner. The bench drives distinct patterns on the latch and on the three peripheral sets, so every owner is visible at the pads. It then samples the pads after the capturing edge, after the next edge and after the one after that. The interrupt edges need the same care: each pin change is held long enough to cross the synchronizer, and the pulse is sampled on the single cycle it may be high, as well as on the cycles on either side of it.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int DW      = 32;
  localparam int REG_AW  = 4;
  localparam int CFG_LAT = 2;
  localparam int XPOL_BIT = 8;

  localparam logic [REG_AW-1:0] ADR_DATA  = 4'd0;
  localparam logic [REG_AW-1:0] ADR_SET   = 4'd1;
  localparam logic [REG_AW-1:0] ADR_CLR   = 4'd2;
  localparam logic [REG_AW-1:0] ADR_TGL   = 4'd3;
  localparam logic [REG_AW-1:0] ADR_DIR   = 4'd4;
  localparam logic [REG_AW-1:0] ADR_PUD   = 4'd5;
  localparam logic [REG_AW-1:0] ADR_FSEL0 = 4'd6;
  localparam logic [REG_AW-1:0] ADR_FSEL1 = 4'd7;
  localparam logic [REG_AW-1:0] ADR_WAKE  = 4'd8;
  localparam logic [REG_AW-1:0] ADR_XCFG0 = 4'd9;

  typedef enum logic [1:0] {
    FN_GPIO  = 2'd0,
    FN_PER_A = 2'd1,
    FN_PER_B = 2'd2,
    FN_PER_C = 2'd3
  } pin_fn_e;

  // The data, set, clear and toggle registers all act on the output latch
  function automatic logic is_latch_addr(logic [REG_AW-1:0] a);
    return a <= ADR_TGL;
  endfunction

  function automatic logic [DW-1:0] latch_next(logic [REG_AW-1:0] a,
                                               logic [DW-1:0] cur,
                                               logic [DW-1:0] w);
    case (a)
      ADR_DATA: return w;
      ADR_SET:  return cur | w;
      ADR_CLR:  return cur & ~w;
      ADR_TGL:  return cur ^ w;
      default:  return cur;
    endcase
  endfunction

  // Returns {enable, value} for one pin; index 0 is the GPIO source
  function automatic logic [1:0] route_pin(pin_fn_e fn, logic [3:0] vals,
                                           logic [3:0] ens);
    return {ens[fn], vals[fn]};
  endfunction
endpackage

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int NXINT = 3,
  parameter logic [NPINS-1:0] PUD_RESET = '0,
  localparam int SELW = $clog2(NPINS),
  localparam int FSW  = 2 * NPINS,
  localparam int FSEL_WORDS = (FSW + DW - 1) / DW
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [REG_AW-1:0]           bus_addr,
  input  logic [DW-1:0]               bus_wdata,
  input  logic [NPINS-1:0]            pin_sync,
  output logic [DW-1:0]               bus_rdata,
  output logic [NPINS-1:0]            latch_q,
  output logic [NPINS-1:0]            dir_q,
  output logic [NPINS-1:0]            pud_q,
  output logic [NPINS-1:0]            wake_mask_q,
  output logic [FSW-1:0]              fsel_q,
  output logic [NXINT-1:0][SELW-1:0]  xsel_q,
  output logic [NXINT-1:0]            xpol_q
);
  logic latch_wr_hit;
  assign latch_wr_hit = bus_wr && is_latch_addr(bus_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q     <= '0;
      dir_q       <= '0;
      pud_q       <= PUD_RESET;
      wake_mask_q <= '0;
      fsel_q      <= '0;
      xsel_q      <= '0;
      xpol_q      <= '0;
    end else begin
      if (latch_wr_hit)
        latch_q <= NPINS'(latch_next(bus_addr, DW'(latch_q), bus_wdata));
      if (bus_wr && bus_addr == ADR_DIR)  dir_q       <= bus_wdata[NPINS-1:0];
      if (bus_wr && bus_addr == ADR_PUD)  pud_q       <= bus_wdata[NPINS-1:0];
      if (bus_wr && bus_addr == ADR_WAKE) wake_mask_q <= bus_wdata[NPINS-1:0];
      for (int w = 0; w < FSEL_WORDS; w++) begin
        if (bus_wr && bus_addr == ADR_FSEL0 + REG_AW'(w)) begin
          for (int b = 0; b < DW; b++)
            if (w * DW + b < FSW) fsel_q[w*DW+b] <= bus_wdata[b];
        end
      end
      for (int k = 0; k < NXINT; k++) begin
        if (bus_wr && bus_addr == ADR_XCFG0 + REG_AW'(k)) begin
          xsel_q[k] <= bus_wdata[SELW-1:0];
          xpol_q[k] <= bus_wdata[XPOL_BIT];
        end
      end
    end
  end

  logic [2*DW-1:0] fsel_wide;
  assign fsel_wide = (2*DW)'(fsel_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_DATA:  bus_rdata = DW'(pin_sync);
      ADR_DIR:   bus_rdata = DW'(dir_q);
      ADR_PUD:   bus_rdata = DW'(pud_q);
      ADR_FSEL0: bus_rdata = fsel_wide[DW-1:0];
      ADR_FSEL1: bus_rdata = fsel_wide[2*DW-1:DW];
      ADR_WAKE:  bus_rdata = DW'(wake_mask_q);
      default:   bus_rdata = '0;
    endcase
    for (int k = 0; k < NXINT; k++) begin
      if (bus_addr == ADR_XCFG0 + REG_AW'(k)) begin
        bus_rdata[SELW-1:0] = xsel_q[k];
        bus_rdata[XPOL_BIT] = xpol_q[k];
      end
    end
  end

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_SET) |=>
      ((latch_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));
  // R3
  set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_SET) |=>
      ((latch_q & ~$past(bus_wdata[NPINS-1:0])) ==
       ($past(latch_q) & ~$past(bus_wdata[NPINS-1:0]))));
  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_CLR) |=>
      ((latch_q & $past(bus_wdata[NPINS-1:0])) == '0));
  // R3
  tgl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_TGL) |=>
      (latch_q == ($past(latch_q) ^ $past(bus_wdata[NPINS-1:0]))));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pin_sync
);
  logic [NPINS-1:0] meta_q;
  logic [NPINS-1:0] sync_q;
  logic [1:0]       primed_cnt;
  logic             primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end
  end

  // Counts edges since reset so the latency check starts on real samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               primed_cnt <= '0;
    else if (primed_cnt != 2'd2) primed_cnt <= primed_cnt + 2'd1;
  end
  assign primed   = (primed_cnt == 2'd2);
  assign pin_sync = sync_q;

  // R7
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (pin_sync == $past(pad_in, 2)));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32,
  localparam int FSW = 2 * NPINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FSW-1:0]   fsel_cfg,
  input  logic [NPINS-1:0] latch,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] per_a_out,
  input  logic [NPINS-1:0] per_a_oe,
  input  logic [NPINS-1:0] per_b_out,
  input  logic [NPINS-1:0] per_b_oe,
  input  logic [NPINS-1:0] per_c_out,
  input  logic [NPINS-1:0] per_c_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] gpio_mode
);
  logic [CFG_LAT-1:0][FSW-1:0] fsel_pipe_q;
  logic [FSW-1:0]              fsel_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_pipe_q <= '0;
    end else begin
      fsel_pipe_q[0] <= fsel_cfg;
      for (int s = 1; s < CFG_LAT; s++) fsel_pipe_q[s] <= fsel_pipe_q[s-1];
    end
  end
  assign fsel_act = fsel_pipe_q[CFG_LAT-1];

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pin_fn_e    fn;
    logic [1:0] routed;
    assign fn     = pin_fn_e'(fsel_act[2*i +: 2]);
    assign routed = route_pin(fn,
                      {per_c_out[i], per_b_out[i], per_a_out[i], latch[i]},
                      {per_c_oe[i],  per_b_oe[i],  per_a_oe[i],  dir[i]});
    assign pad_out[i]   = routed[0];
    assign pad_oe[i]    = routed[1];
    assign gpio_mode[i] = (fn == FN_GPIO);
  end

  // R6
  cfg_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsel_act == $past(fsel_cfg, 2));
  // R4
  no_stray_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & gpio_mode & ~dir) == '0);
endmodule

// File: rtl/gpio_xint_unit.sv
module gpio_xint_unit #(
  parameter int NPINS = 32,
  localparam int SELW = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_sync,
  input  logic [SELW-1:0]  sel,
  input  logic             rising,
  output logic             pulse
);
  logic level;
  logic prev_q;

  assign level = pin_sync[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign pulse = rising ? (level & ~prev_q) : (~level & prev_q);

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  // R8
  pulse_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (level == rising));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int NXINT = 3,
  parameter logic [NPINS-1:0] PUD_RESET = 32'h0000_00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pu_en,
  input  logic [NPINS-1:0]  per_a_out,
  input  logic [NPINS-1:0]  per_a_oe,
  input  logic [NPINS-1:0]  per_b_out,
  input  logic [NPINS-1:0]  per_b_oe,
  input  logic [NPINS-1:0]  per_c_out,
  input  logic [NPINS-1:0]  per_c_oe,
  output logic [NPINS-1:0]  pin_level,
  output logic [NXINT-1:0]  xint_pulse,
  output logic              wake_o
);
  localparam int SELW = $clog2(NPINS);
  localparam int FSW  = 2 * NPINS;

  logic [NPINS-1:0]           pin_sync;
  logic [NPINS-1:0]           latch_q, dir_q, pud_q, wake_mask_q, gpio_mode;
  logic [FSW-1:0]             fsel_q;
  logic [NXINT-1:0][SELW-1:0] xsel_q;
  logic [NXINT-1:0]           xpol_q;

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pin_sync(pin_sync)
  );

  gpio_cfg_bank #(.NPINS(NPINS), .NXINT(NXINT), .PUD_RESET(PUD_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pin_sync(pin_sync), .bus_rdata(bus_rdata),
    .latch_q(latch_q), .dir_q(dir_q), .pud_q(pud_q),
    .wake_mask_q(wake_mask_q), .fsel_q(fsel_q), .xsel_q(xsel_q),
    .xpol_q(xpol_q)
  );

  gpio_pad_mux #(.NPINS(NPINS)) u_mux (
    .clk(clk), .rst_n(rst_n), .fsel_cfg(fsel_q), .latch(latch_q),
    .dir(dir_q), .per_a_out(per_a_out), .per_a_oe(per_a_oe),
    .per_b_out(per_b_out), .per_b_oe(per_b_oe), .per_c_out(per_c_out),
    .per_c_oe(per_c_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .gpio_mode(gpio_mode)
  );

  for (genvar k = 0; k < NXINT; k++) begin : g_xint
    gpio_xint_unit #(.NPINS(NPINS)) u_xint (
      .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .sel(xsel_q[k]),
      .rising(xpol_q[k]), .pulse(xint_pulse[k])
    );
  end

  assign pin_level = pin_sync;
  assign pad_pu_en = ~pud_q;
  assign wake_o    = |(wake_mask_q & ~pin_sync);

  // R9
  wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_mask_q == '0) |-> !wake_o);
  // R1
  gpio_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_mode == '1 && dir_q == '0) |-> (pad_oe == '0));
endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  localparam logic [31:0] PUD_RST = 32'h0000_00FF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] pad_in, pad_out, pad_oe, pad_pu_en, pin_level;
  logic [31:0] per_a_out, per_a_oe, per_b_out, per_b_oe, per_c_out, per_c_oe;
  logic [2:0]  xint_pulse;
  logic        wake_o;

  int n_checks = 0;
  int n_err    = 0;
  logic [31:0] exp_latch, exp_dir, exp_lo, exp_hi;

  always #10 clk = ~clk;

  gpio_port_ctrl #(.NPINS(32), .NXINT(3), .PUD_RESET(PUD_RST)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en),
    .per_a_out(per_a_out), .per_a_oe(per_a_oe), .per_b_out(per_b_out),
    .per_b_oe(per_b_oe), .per_c_out(per_c_out), .per_c_oe(per_c_oe),
    .pin_level(pin_level), .xint_pulse(xint_pulse), .wake_o(wake_o)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Pad model: code 0 latch/dir, 1/2/3 peripheral A/B/C; returns {oe, out}
  function automatic logic [63:0] model_pads(logic [31:0] lo, logic [31:0] hi,
                                             logic [31:0] lat, logic [31:0] dr);
    logic [31:0] o, e;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] code;
      code = (i < 16) ? lo[2*i +: 2] : hi[2*(i-16) +: 2];
      case (code)
        2'd0: begin o[i] = lat[i];       e[i] = dr[i];       end
        2'd1: begin o[i] = per_a_out[i]; e[i] = per_a_oe[i]; end
        2'd2: begin o[i] = per_b_out[i]; e[i] = per_b_oe[i]; end
        default: begin o[i] = per_c_out[i]; e[i] = per_c_oe[i]; end
      endcase
    end
    return {e, o};
  endfunction

  task automatic chk_pads(input string req);
    logic [63:0] m;
    m = model_pads(exp_lo, exp_hi, exp_latch, exp_dir);
    chk({req, " out"}, pad_out, m[31:0]);
    chk({req, " oe"},  pad_oe,  m[63:32]);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 reset pad_oe", pad_oe, 32'h0);
    chk("R1 reset pad_out", pad_out, 32'h0);
    reg_rd(4'd4, d); chk("R1 reset dir", d, 32'h0);
    reg_rd(4'd6, d); chk("R1 reset fsel0", d, 32'h0);
    reg_rd(4'd7, d); chk("R1 reset fsel1", d, 32'h0);
    reg_rd(4'd5, d); chk("R2 reset pud", d, PUD_RST);
    chk("R2 reset pu_en", pad_pu_en, ~PUD_RST);
    chk("R8 reset xint", {29'h0, xint_pulse}, 32'h0);
    chk("R9 reset wake", {31'h0, wake_o}, 32'h0);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    reg_wr(4'd0, 32'hA5A5_0F0F); exp_latch = 32'hA5A5_0F0F;
    chk("R3 data load", pad_out, exp_latch);
    reg_wr(4'd1, 32'h0000_00F0); exp_latch = exp_latch | 32'h0000_00F0;
    chk("R3 set", pad_out, exp_latch);
    reg_wr(4'd2, 32'hA500_0000); exp_latch = exp_latch & ~32'hA500_0000;
    chk("R3 clear", pad_out, exp_latch);
    reg_wr(4'd3, 32'hFFFF_0000); exp_latch = exp_latch ^ 32'hFFFF_0000;
    chk("R3 toggle", pad_out, exp_latch);
    reg_wr(4'd1, 32'h0); reg_wr(4'd2, 32'h0); reg_wr(4'd3, 32'h0);
    chk("R3 zero writes no effect", pad_out, exp_latch);
    chk("R4 inputs not driven", pad_oe, 32'h0);
    reg_rd(4'd1, d); chk("R10 set reads zero", d, 32'h0);
    reg_rd(4'd2, d); chk("R10 clear reads zero", d, 32'h0);
    reg_rd(4'd3, d); chk("R10 toggle reads zero", d, 32'h0);
  endtask

  task automatic t_drive();
    reg_wr(4'd2, 32'hFFFF_FFFF);
    reg_wr(4'd1, 32'h8000_0001); exp_latch = 32'h8000_0001;
    chk("R4 still input after preload", pad_oe, 32'h0);
    reg_wr(4'd4, 32'h8000_0003); exp_dir = 32'h8000_0003;
    chk("R4 first driven enable", pad_oe, 32'h8000_0003);
    chk("R4 first driven value", pad_out, 32'h8000_0001);
  endtask

  task automatic t_pud();
    logic [31:0] d;
    reg_wr(4'd5, 32'h1234_5678);
    chk("R2 pu_en follows pud", pad_pu_en, ~32'h1234_5678);
    reg_rd(4'd5, d); chk("R10 pud readback", d, 32'h1234_5678);
  endtask

  task automatic t_fsel();
    logic [31:0] d;
    reg_wr(4'd4, 32'h0F0F_0F0F); exp_dir = 32'h0F0F_0F0F;
    reg_wr(4'd0, 32'h3C3C_C3C3); exp_latch = 32'h3C3C_C3C3;
    chk_pads("R4 gpio mode");
    reg_wr(4'd6, 32'h5555_5555);
    reg_rd(4'd6, d); chk("R6 fsel0 immediate readback", d, 32'h5555_5555);
    chk_pads("R6 old after capture edge");
    wait_neg(1); chk_pads("R6 old after one more edge");
    wait_neg(1); exp_lo = 32'h5555_5555; chk_pads("R5 R6 set A after two edges");
    reg_wr(4'd7, 32'hFFFF_FFFF);
    wait_neg(1); chk_pads("R6 hi old");
    wait_neg(1); exp_hi = 32'hFFFF_FFFF; chk_pads("R5 set C on high pins");
    reg_wr(4'd6, 32'hAAAA_AAAA);
    wait_neg(2); exp_lo = 32'hAAAA_AAAA; chk_pads("R5 set B on low pins");
    reg_wr(4'd6, 32'h1B1B_E4E4);
    wait_neg(2); exp_lo = 32'h1B1B_E4E4; chk_pads("R5 mixed codes");
    reg_wr(4'd6, 32'h0); reg_wr(4'd7, 32'h0);
    wait_neg(2); exp_lo = 0; exp_hi = 0; chk_pads("R5 back to gpio");
  endtask

  task automatic t_sync();
    logic [31:0] d;
    reg_wr(4'd4, 32'h0000_FFFF); exp_dir = 32'h0000_FFFF;
    pad_in = 32'h1357_9BDF;
    reg_rd(4'd0, d); chk("R7 no change before edge", d, 32'h0);
    wait_neg(1); reg_rd(4'd0, d); chk("R7 hidden after one edge", d, 32'h0);
    wait_neg(1); reg_rd(4'd0, d); chk("R7 visible after two edges", d, 32'h1357_9BDF);
    chk("R7 pin_level", pin_level, 32'h1357_9BDF);
    reg_wr(4'd4, 32'h0); exp_dir = 0;
  endtask

  task automatic t_xint();
    logic [31:0] d;
    pad_in = 32'h0; wait_neg(3);
    reg_wr(4'd9,  32'h0000_0105);
    reg_wr(4'd10, 32'h0000_001F);
    reg_wr(4'd11, 32'h0000_0005);
    wait_neg(1);
    reg_rd(4'd9, d);  chk("R8 xcfg0 readback", d, 32'h0000_0105);
    reg_rd(4'd10, d); chk("R8 xcfg1 readback", d, 32'h0000_001F);
    chk("R8 quiet after config", {29'h0, xint_pulse}, 32'h0);
    pad_in[5] = 1'b1;
    wait_neg(1); chk("R8 rise not yet", {29'h0, xint_pulse}, 32'h0);
    wait_neg(1); chk("R8 rising pulse line0", {29'h0, xint_pulse}, 32'h1);
    wait_neg(1); chk("R8 rising pulse one cycle", {29'h0, xint_pulse}, 32'h0);
    pad_in[5] = 1'b0;
    wait_neg(2); chk("R8 falling pulse line2", {29'h0, xint_pulse}, 32'h4);
    wait_neg(1); chk("R8 falling pulse one cycle", {29'h0, xint_pulse}, 32'h0);
    pad_in[31] = 1'b1;
    wait_neg(2); chk("R8 rise ignored on falling line", {29'h0, xint_pulse}, 32'h0);
    wait_neg(1);
    pad_in[31] = 1'b0;
    wait_neg(2); chk("R8 falling pulse line1", {29'h0, xint_pulse}, 32'h2);
    wait_neg(1); chk("R8 line1 one cycle", {29'h0, xint_pulse}, 32'h0);
  endtask

  task automatic t_wake();
    logic [31:0] d;
    pad_in = 32'hFFFF_FFFF; wait_neg(3);
    chk("R9 no mask no wake", {31'h0, wake_o}, 32'h0);
    reg_wr(4'd8, 32'h0000_0100);
    reg_rd(4'd8, d); chk("R10 wake mask readback", d, 32'h0000_0100);
    pad_in[9] = 1'b0;
    wait_neg(3); chk("R9 unmasked low ignored", {31'h0, wake_o}, 32'h0);
    pad_in[8] = 1'b0;
    wait_neg(1); chk("R9 not before sync", {31'h0, wake_o}, 32'h0);
    wait_neg(1); chk("R9 masked low wakes", {31'h0, wake_o}, 32'h1);
    pad_in[8] = 1'b1;
    wait_neg(2); chk("R9 released", {31'h0, wake_o}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    per_a_out = 32'h1111_EEEE; per_a_oe = 32'hF0F0_F0F0;
    per_b_out = 32'h2468_ACE0; per_b_oe = 32'h0FF0_0FF0;
    per_c_out = 32'h9999_6666; per_c_oe = 32'hFFFF_0000;
    exp_latch = 0; exp_dir = 0; exp_lo = 0; exp_hi = 0;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(1);
    t_reset();
    t_latch();
    t_drive();
    t_pud();
    t_fsel();
    t_sync();
    t_xint();
    t_wake();
    finish_run();
  end
endmodule